// File: doc/BRIEF.md
# Trace Capture Core with Sequential Trigger Levels

This block records a bus of internal probe signals into an on-chip sample buffer, one sample per clock, and decides when to stop recording by walking a chain of trigger levels. Each level is a per-bit comparison of the probe bus against a programmed value, with a care mask selecting the bits that take part. The levels must be satisfied one after the other, starting from the first. An active-low trigger input from outside may replace the level chain as the trigger source.

Two recording styles are offered. In ring mode the buffer is overwritten until the trigger, then a fixed share of the depth is recorded after it: seven eighths, one half or one eighth of the buffer, which places the trigger early, mid or late in the stored window. In segment mode the buffer is cut into a power-of-two number of equal slices. Each slice starts with its own trigger sample followed by the samples that come after it, and the level chain starts again from the first level for every slice. After the capture ends, the buffer is read out through a synchronous port addressed relative to the oldest stored sample. An active-low trigger output pulses a fixed number of cycles after each trigger, so it can feed the trigger input of a second core.

Top module: `trace_capture`

## Requirements
- R1: After a synchronous reset, `done` and `busy` are 0, `trig_out_n` is 1, and `valid_cnt` and `trig_idx` are 0.
- R2: An `arm` pulse while idle or done takes the configuration inputs and makes `busy` 1 from the next cycle. In ring modes one probe sample is stored on every clock edge while `busy` is 1.
- R3: A sample satisfies level k when `((probe ^ lvl_val[k]) & lvl_care[k]) == 0`. Level k occupies bits `k*PW +: PW` of `lvl_val` and `lvl_care`, and a care bit of 0 makes that probe bit a don't-care.
- R4: With `cfg_ext` = 0, the chain starts at level 0 and advances by one level on each sample that satisfies the current level. The trigger is the sample that satisfies level `cfg_last`. Only one level can be satisfied per sample.
- R5: With `cfg_ext` = 1, the trigger is the first sample stored while `ext_trig_n` is 0, and the level masks have no effect.
- R6: `cfg_mode` 0, 1 and 2 are ring modes that record DEPTH*7/8, DEPTH/2 and DEPTH/8 samples after the trigger sample. `done` becomes 1 on the edge that stores the last of these samples.
- R7: While `done` is 1, `rd_data` shows, one cycle after `rd_addr` is presented, the sample at position `rd_addr` counted from the oldest stored sample (position 0). `trig_idx` gives the position of the trigger sample.
- R8: `valid_cnt` equals the number of samples stored in the run, capped at DEPTH, so a trigger that arrives before the buffer has filled gives a count below DEPTH.
- R9: `cfg_mode` 3 splits the buffer into 2^`cfg_seg` slices of DEPTH>>`cfg_seg` samples. No sample is stored while waiting for a trigger. Each slice holds its trigger sample followed by the samples after it, the chain restarts at level 0 for each slice, and `done` follows the last slice. `valid_cnt` is DEPTH and `trig_idx` is 0.
- R10: `trig_out_n` is 0 for exactly one cycle, after the fourth clock edge that follows the edge which stored a trigger sample.
- R11: An `arm` pulse while done clears `done` on the next edge and starts a new run at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| probe | input | PW | Probe bus being recorded |
| lvl_val | input | LEVELS*PW | Compare values, one PW slice per level |
| lvl_care | input | LEVELS*PW | Care masks, one PW slice per level |
| cfg_mode | input | 2 | 0/1/2 ring with 7/8, 1/2, 1/8 post share; 3 segment mode |
| cfg_last | input | clog2(LEVELS) | Index of the final trigger level |
| cfg_ext | input | 1 | Use the external trigger instead of the level chain |
| cfg_seg | input | clog2(MAX_SEG_LOG+1) | log2 of the number of slices in segment mode |
| arm | input | 1 | Start pulse, accepted while idle or done |
| ext_trig_n | input | 1 | External trigger, active low |
| trig_out_n | output | 1 | Delayed trigger pulse, active low |
| done | output | 1 | Capture finished, buffer readable |
| busy | output | 1 | Capture run in progress |
| valid_cnt | output | clog2(DEPTH)+1 | Number of genuine stored samples |
| trig_idx | output | clog2(DEPTH) | Position of the trigger sample from the oldest sample |
| rd_addr | input | clog2(DEPTH) | Read position, relative to the oldest sample |
| rd_data | output | PW | Read sample, one cycle after the address |

## Verification
The assertions take for granted that `ext_trig_n` and `probe` are already synchronous to `clk`, that `arm` is a single-cycle pulse, and that `cfg_last` does not exceed LEVELS-1. The one-cycle trigger pulse property also relies on triggers never falling on back-to-back edges, which holds because every ring post-count and every slice is at least two samples long. The stimulus changes every input only on the falling edge of the clock. It holds the configuration steady for the whole run, raises `arm` for one cycle only, and drives `ext_trig_n` low for a single sample.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_POST  = 2'd2,
    S_DONE  = 2'd3
  } trc_state_e;

  typedef enum logic [1:0] {
    M_TRIG_EARLY = 2'd0,
    M_TRIG_MID   = 2'd1,
    M_TRIG_LATE  = 2'd2,
    M_SEGMENT    = 2'd3
  } trc_mode_e;
endpackage

// File: rtl/trc_match.sv
module trc_match #(
  parameter int PW     = 8,
  parameter int LEVELS = 4
) (
  input  logic [PW-1:0]        sample,
  input  logic [LEVELS*PW-1:0] val,
  input  logic [LEVELS*PW-1:0] care,
  output logic [LEVELS-1:0]    hit
);
  // one comparator per level, all evaluated against the same sample
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign hit[g] = ~|((sample ^ val[g*PW +: PW]) & care[g*PW +: PW]);
  end
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int PW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  logic [PW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_dly.sv
module trc_dly #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= STAGES'({sr, din});
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trc_pkg::*;
#(
  parameter int PW          = 8,
  parameter int DEPTH       = 64,
  parameter int LEVELS      = 4,
  parameter int MAX_SEG_LOG = 3,
  parameter int TRIG_DLY    = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = AW + 1,
  localparam int LVW = $clog2(LEVELS),
  localparam int SGW = $clog2(MAX_SEG_LOG + 1),
  localparam int SCW = MAX_SEG_LOG + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        probe,
  input  logic [LEVELS*PW-1:0] lvl_val,
  input  logic [LEVELS*PW-1:0] lvl_care,
  input  logic [1:0]           cfg_mode,
  input  logic [LVW-1:0]       cfg_last,
  input  logic                 cfg_ext,
  input  logic [SGW-1:0]       cfg_seg,
  input  logic                 arm,
  input  logic                 ext_trig_n,
  output logic                 trig_out_n,
  output logic                 done,
  output logic                 busy,
  output logic [CW-1:0]        valid_cnt,
  output logic [AW-1:0]        trig_idx,
  input  logic [AW-1:0]        rd_addr,
  output logic [PW-1:0]        rd_data
);
  initial begin
    if (DEPTH < 16 || (1 << AW) != DEPTH) $error("DEPTH must be a power of two >= 16");
    if (LEVELS < 2 || LEVELS > 10)        $error("LEVELS must be 2..10");
    if (MAX_SEG_LOG >= AW - 1)            $error("slices must hold at least 4 samples");
  end

  trc_state_e      st;
  trc_mode_e       mode_q;
  logic [LVW-1:0]  last_q;
  logic            ext_q;
  logic [SGW-1:0]  seg_q;
  logic [LVW-1:0]  lvl;
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   trig_ptr;
  logic [AW-1:0]   oldest_q;
  logic [CW-1:0]   post_cnt;
  logic [CW-1:0]   total;
  logic [SCW-1:0]  segs_left;
  logic            fire_q;

  logic [LEVELS-1:0] hit;
  logic            lvl_hit, trig_ev, fire, step, wr_en, last_wr, seg_mode;
  logic [SGW-1:0]  seg_eff;
  logic [CW-1:0]   seg_len, post_len, total_inc;
  logic [AW-1:0]   oldest_n;

  trc_match #(.PW(PW), .LEVELS(LEVELS)) u_match (
    .sample(probe), .val(lvl_val), .care(lvl_care), .hit(hit)
  );

  // ---------------- trigger sequencing ----------------
  assign seg_mode = (mode_q == M_SEGMENT);
  assign lvl_hit  = hit[lvl];
  assign trig_ev  = ext_q ? ~ext_trig_n : (lvl_hit && (lvl == last_q));
  assign fire     = (st == S_ARMED) && trig_ev;
  assign step     = (st == S_ARMED) && !ext_q && lvl_hit && (lvl != last_q);

  // ---------------- write side ----------------
  assign wr_en     = ((st == S_ARMED) && (!seg_mode || fire)) || (st == S_POST);
  assign last_wr   = (st == S_POST) && (post_cnt == CW'(1));
  assign total_inc = (total == CW'(DEPTH)) ? total : total + CW'(1);
  assign oldest_n  = (total_inc == CW'(DEPTH)) ? wptr + AW'(1) : '0;

  assign seg_eff = (cfg_seg > SGW'(MAX_SEG_LOG)) ? SGW'(MAX_SEG_LOG) : cfg_seg;
  assign seg_len = CW'(DEPTH) >> seg_q;

  always_comb begin
    case (mode_q)
      M_TRIG_EARLY: post_len = CW'(DEPTH - DEPTH / 8);
      M_TRIG_MID:   post_len = CW'(DEPTH / 2);
      M_TRIG_LATE:  post_len = CW'(DEPTH / 8);
      M_SEGMENT:    post_len = seg_len - CW'(1);
      default:      post_len = CW'(DEPTH / 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mode_q    <= M_TRIG_MID;
      last_q    <= '0;
      ext_q     <= 1'b0;
      seg_q     <= '0;
      lvl       <= '0;
      wptr      <= '0;
      trig_ptr  <= '0;
      oldest_q  <= '0;
      post_cnt  <= '0;
      total     <= '0;
      segs_left <= '0;
      fire_q    <= 1'b0;
      valid_cnt <= '0;
      trig_idx  <= '0;
    end else begin
      fire_q <= fire;
      if (wr_en) begin
        wptr  <= wptr + AW'(1);
        total <= total_inc;
      end
      case (st)
        S_IDLE, S_DONE: begin
          if (arm) begin
            st        <= S_ARMED;
            mode_q    <= trc_mode_e'(cfg_mode);
            last_q    <= cfg_last;
            ext_q     <= cfg_ext;
            seg_q     <= seg_eff;
            segs_left <= (SCW'(1) << seg_eff) - SCW'(1);
            lvl       <= '0;
            wptr      <= '0;
            total     <= '0;
            valid_cnt <= '0;
            trig_idx  <= '0;
          end
        end
        S_ARMED: begin
          if (step) lvl <= lvl + LVW'(1);
          if (fire) begin
            post_cnt <= post_len;
            trig_ptr <= wptr;
            st       <= S_POST;
          end
        end
        S_POST: begin
          post_cnt <= post_cnt - CW'(1);
          if (last_wr) begin
            if (seg_mode && segs_left != '0) begin
              segs_left <= segs_left - SCW'(1);
              lvl       <= '0;
              st        <= S_ARMED;
            end else begin
              st        <= S_DONE;
              valid_cnt <= total_inc;
              oldest_q  <= oldest_n;
              trig_idx  <= seg_mode ? '0 : trig_ptr - oldest_n;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done = (st == S_DONE);
  assign busy = (st == S_ARMED) || (st == S_POST);

  trc_ram #(.PW(PW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(probe),
    .re(done), .raddr(oldest_q + rd_addr), .rdata(rd_data)
  );

  logic dly_out;
  trc_dly #(.STAGES(TRIG_DLY)) u_dly (
    .clk(clk), .rst(rst), .din(fire_q), .dout(dly_out)
  );
  assign trig_out_n = ~dly_out;

  // ---------------- assertions ----------------
  a_r4_level_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lvl <= last_q));

  a_r6_post_holds: assert property (@(posedge clk) disable iff (rst)
    (st == S_POST && post_cnt > CW'(1)) |=> (st == S_POST));

  a_r9_slice_aligned: assert property (@(posedge clk) disable iff (rst)
    (fire && seg_mode) |-> ((wptr & AW'(seg_len - CW'(1))) == '0));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> (done && $stable(valid_cnt) && $stable(trig_idx)));

  a_r8_valid_bounded: assert property (@(posedge clk) disable iff (rst)
    done |-> (valid_cnt <= CW'(DEPTH) && valid_cnt != '0));

  a_r10_single_low: assert property (@(posedge clk) disable iff (rst)
    !trig_out_n |=> trig_out_n);

  a_r11_rearm_clears: assert property (@(posedge clk) disable iff (rst)
    (done && arm) |=> (!done && busy));
endmodule

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
  localparam int PW = 8, DEPTH = 64, LEVELS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [PW-1:0] probe = '0;
  logic [LEVELS*PW-1:0] lv = '0, lc = '0;
  logic [1:0] cfg_mode = '0;
  logic [1:0] cfg_last = '0;
  logic cfg_ext = 1'b0;
  logic [1:0] cfg_seg = '0;
  logic arm = 1'b0, ext_trig_n = 1'b1;
  logic trig_out_n, done, busy;
  logic [6:0] valid_cnt;
  logic [5:0] trig_idx, rd_addr = '0;
  logic [PW-1:0] rd_data;

  trace_capture u0 (
    .clk(clk), .rst(rst), .probe(probe), .lvl_val(lv), .lvl_care(lc),
    .cfg_mode(cfg_mode), .cfg_last(cfg_last), .cfg_ext(cfg_ext), .cfg_seg(cfg_seg),
    .arm(arm), .ext_trig_n(ext_trig_n), .trig_out_n(trig_out_n), .done(done),
    .busy(busy), .valid_cnt(valid_cnt), .trig_idx(trig_idx), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_st = 0, m_lvl = 0, m_rem = 0, m_segs = 0, m_tidx = 0;
  int m_mode = 0, m_last = 0, m_ext = 0, m_seg = 0;
  logic [PW-1:0] q[$];
  bit hist[$];

  function automatic bit level_ok(int k);
    return ((probe ^ lv[k*PW +: PW]) & lc[k*PW +: PW]) == '0;
  endfunction

  function automatic int post_share(int md, int sg);
    case (md)
      0: return DEPTH * 7 / 8;
      1: return DEPTH / 2;
      2: return DEPTH / 8;
      default: return (DEPTH >> sg) - 1;
    endcase
  endfunction

  task automatic store(logic [PW-1:0] s);
    q.push_back(s);
    if (q.size() > DEPTH) begin
      void'(q.pop_front());
      m_tidx--;
    end
  endtask

  always @(posedge clk) begin
    bit f;
    f = 1'b0;
    cyc++;
    if (rst) begin
      m_st = 0;
    end else begin
      case (m_st)
        0, 3: if (arm) begin
          m_st = 1; m_lvl = 0; q.delete(); m_tidx = 0;
          m_mode = cfg_mode; m_last = cfg_last; m_ext = cfg_ext;
          m_seg = cfg_seg; m_segs = (1 << cfg_seg) - 1;
        end
        1: begin
          if (m_ext != 0) f = !ext_trig_n;
          else if (level_ok(m_lvl)) begin
            if (m_lvl == m_last) f = 1'b1; else m_lvl++;
          end
          if (m_mode != 3 || f) store(probe);
          if (f) begin
            m_tidx = (m_mode == 3) ? 0 : q.size() - 1;
            m_rem = post_share(m_mode, m_seg);
            m_st = 2;
          end
        end
        default: begin
          store(probe);
          m_rem--;
          if (m_rem == 0) begin
            if (m_mode == 3 && m_segs > 0) begin m_segs--; m_lvl = 0; m_st = 1; end
            else m_st = 3;
          end
        end
      endcase
    end
    hist.push_back(f);
  end

  // per-cycle comparison of status and trigger output
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy", busy, (m_st == 1 || m_st == 2));
      chk("R6/R11 done", done, (m_st == 3));
      chk("R10 trig_out_n", trig_out_n,
          !(hist.size() >= 5 && hist[hist.size() - 5]));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    n_fail++; n_chk++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    finish_run();
  end

  task automatic run(string tag, int md, int last, int ext, int sg, int ext_at);
    int k;
    @(negedge clk);
    cfg_mode = md[1:0]; cfg_last = last[1:0]; cfg_ext = ext[0]; cfg_seg = sg[1:0];
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    k = 0;
    while (!done && k < 3000) begin
      probe = k[PW-1:0];
      ext_trig_n = !(k == ext_at);
      @(negedge clk);
      k++;
    end
    ext_trig_n = 1'b1;
    chk({tag, " R8 valid_cnt"}, valid_cnt, q.size());
    chk({tag, " R7 trig_idx"}, trig_idx, m_tidx);
    for (int i = 0; i < q.size(); i++) begin
      rd_addr = i[5:0];
      @(negedge clk);
      chk({tag, " R7 rd_data"}, rd_data, q[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 trig_out_n", trig_out_n, 1);
    chk("R1 valid_cnt", valid_cnt, 0);
    chk("R1 trig_idx", trig_idx, 0);

    // R3/R4/R6 mid position, two exact levels 0x10 then 0x20
    lv = {8'h00, 8'h00, 8'h20, 8'h10}; lc = {8'h00, 8'h00, 8'hFF, 8'hFF};
    run("mid", 1, 1, 0, 0, -1);
    chk("R6 mid trig_idx", trig_idx, 31);

    // R5/R6 early position, external trigger; levels always match (care 0)
    lc = '0;
    run("ext", 0, 0, 1, 0, 100);
    chk("R5 ext trig_idx", trig_idx, 7);

    // R8 late position with trigger before the buffer fills
    lv = {24'h0, 8'h03}; lc = {24'h0, 8'hFF};
    run("late", 2, 0, 0, 0, -1);
    chk("R8 early valid", valid_cnt, 12);
    chk("R8 early trig", trig_idx, 3);

    // R3 don't-care bits, R4 three-level ordering
    lv = {8'h00, 8'h80, 8'h40, 8'hA5}; lc = {8'h00, 8'h80, 8'hFF, 8'h0F};
    run("seq", 1, 2, 0, 0, -1);
    chk("R4 seq trig_idx", trig_idx, 31);
    chk("R3 trigger sample", q[m_tidx], 8'h80);

    // R9 segment mode, four slices, chain restarts per slice; R11 rearm
    lv = {16'h0, 8'h04, 8'h00}; lc = {16'h0, 8'h0F, 8'h0F};
    run("seg4", 3, 1, 0, 2, -1);
    chk("R9 slice start", q[16], 8'h24);

    // R9 eight slices, single level
    lv = {24'h0, 8'h01}; lc = {24'h0, 8'h03};
    run("seg8", 3, 0, 0, 3, -1);

    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule